// File: doc/BRIEF.md
# Interrupt Message Slot Array

This block sits inside a device and holds a small table of interrupt message slots. Each slot stores a 64-bit destination address, split into low and high words, a 32-bit data word and a 32-bit control word. Host software reads and writes the table through a flat 32-bit register port. Device logic supplies one event line per slot. When an event rises on an unmasked slot, the block emits a single message write made of that slot's address and data. The message leaves on a valid/ready output, which a transaction layer downstream turns into a bus write.

Each address-low write is held in a per-slot shadow register. It takes effect only when the data word of the same slot is written. This way the emitter never pairs a new address with stale data, even though the host updates the two words one at a time. An event that arrives while the slot is masked is remembered and sent once the slot is unmasked. When several slots are ready at once, they take turns through a round-robin arbiter.

The output follows valid/ready rules. Once `msg_valid` is high, `msg_addr` and `msg_data` stay fixed until a cycle in which `msg_ready` is also high. Holding `msg_ready` low stalls delivery but loses nothing: events keep collecting as pending bits and drain later in arbitration order.

Top module: `irqm_array`

## Requirements
- R1: After reset every slot word reads zero, every slot is masked and `msg_valid` is low.
- R2: Slot s occupies register byte offsets 16*s + {0,4,8,12}, holding address low, address high, data and control. Address high and control read back the full 32 bits last written.
- R3: A write to offset 0 of a slot is staged. The value read at offset 0 and the address low used in messages stay at the old value until the slot's data word (offset 8) is written. That write commits the staged address low and the new data together.
- R4: Control bit 0 is the unmask bit (1 = may deliver). The other control bits are stored but have no effect. Writing zero to all four words of a slot leaves it masked, with zero address and zero data.
- R5: A rising edge on `evt[s]` while slot s is unmasked produces exactly one message with `msg_addr` = {address high, address low} and `msg_data` = the data word of slot s.
- R6: A rising edge on a masked slot produces no message. It sets a pending flag, and the message is sent once when the slot is next unmasked. A later mask and unmask with no new edge sends nothing.
- R7: Delivery is one-shot. An event held high for many cycles yields a single message.
- R8: When several slots are pending and unmasked, the next one granted is the first at or after (last granted + 1), wrapping at NUM_SLOTS. After reset the search starts at slot 0.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` stay unchanged.
- R10: Register reads at a slot index of NUM_SLOTS or above return zero, and writes there change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| evt | input | NUM_SLOTS | Per-slot event lines, rising-edge sensitive |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Downstream accepts message |
| msg_addr | output | 64 | Message destination address |
| msg_data | output | 32 | Message payload |

## Verification
The assertions assume that the event lines are low while reset is asserted. If they were not, the edge detector would see a rising edge on the first cycle after reset. The bench keeps every event line at zero from time zero. The stability property also assumes that downstream never takes back a message it has been offered. The bench therefore lowers `msg_ready` only between handshakes and keeps it low until it deliberately releases a held message. All stimulus changes on the falling clock edge.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    W_ADDR_LO = 2'd0,
    W_ADDR_HI = 2'd1,
    W_DATA    = 2'd2,
    W_CTRL    = 2'd3
  } word_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] addr_hi;
    logic [WORD_W-1:0] addr_lo;
    logic [WORD_W-1:0] data;
  } msg_t;
endpackage

// File: rtl/irqm_slot_bank.sv
module irqm_slot_bank
  import irqm_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int REG_AW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  output msg_t [NUM_SLOTS-1:0]  slot_msg,
  output logic [NUM_SLOTS-1:0]  unmask
);
  localparam int IDX_W = REG_AW - 4;

  logic [IDX_W-1:0] idx;
  word_sel_e        wsel;
  logic             in_range;
  logic [WORD_W-1:0] rd_word [NUM_SLOTS];

  assign idx      = reg_addr[REG_AW-1:4];
  assign wsel     = word_sel_e'(reg_addr[3:2]);
  assign in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_SLOTS));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [WORD_W-1:0] lo_q, stage_q, hi_q, data_q, ctrl_q;
    logic              hit;

    assign hit = reg_we && in_range && (idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q    <= '0;
        stage_q <= '0;
        hi_q    <= '0;
        data_q  <= '0;
        ctrl_q  <= '0;
      end else if (hit) begin
        unique case (wsel)
          W_ADDR_LO: stage_q <= reg_wdata;
          W_ADDR_HI: hi_q    <= reg_wdata;
          W_DATA: begin
            data_q <= reg_wdata;
            lo_q   <= stage_q;
          end
          W_CTRL:    ctrl_q  <= reg_wdata;
          default: ;
        endcase
      end
    end

    always_comb begin
      unique case (wsel)
        W_ADDR_LO: rd_word[s] = lo_q;
        W_ADDR_HI: rd_word[s] = hi_q;
        W_DATA:    rd_word[s] = data_q;
        default:   rd_word[s] = ctrl_q;
      endcase
    end

    assign slot_msg[s] = '{addr_hi: hi_q, addr_lo: lo_q, data: data_q};
    assign unmask[s]   = ctrl_q[0];
  end

  always_comb begin
    reg_rdata = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (in_range && idx == IDX_W'(s)) reg_rdata = rd_word[s];
    end
  end
endmodule

// File: rtl/irqm_pend.sv
module irqm_pend #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] evt,
  input  logic [NUM_SLOTS-1:0] claim,
  output logic [NUM_SLOTS-1:0] rise,
  output logic [NUM_SLOTS-1:0] pend
);
  logic [NUM_SLOTS-1:0] evt_q;

  assign rise = evt & ~evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      pend  <= '0;
    end else begin
      evt_q <= evt;
      pend  <= (pend & ~claim) | rise;
    end
  end
endmodule

// File: rtl/irqm_rr_arb.sv
module irqm_rr_arb #(
  parameter int NUM_SLOTS = 4,
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] req,
  input  logic                 advance,
  output logic [NUM_SLOTS-1:0] gnt,
  output logic [IW-1:0]        gnt_idx
);
  logic [IW-1:0] last_q;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int off = 1; off <= NUM_SLOTS; off++) begin
      int j;
      j = (int'(last_q) + off) % NUM_SLOTS;
      if (!found && req[j]) begin
        gnt[j]  = 1'b1;
        gnt_idx = IW'(j);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(NUM_SLOTS - 1);
    else if (advance && found) last_q <= gnt_idx;
  end
endmodule

// File: rtl/irqm_array.sv
module irqm_array
  import irqm_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int REG_AW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_SLOTS-1:0] evt,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [63:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  msg_t [NUM_SLOTS-1:0] slot_msg;
  logic [NUM_SLOTS-1:0] unmask_vec, pend_vec, rise_vec, req_vec, arb_gnt, claim_vec;
  logic [IW-1:0]        gnt_idx;
  logic                 load;
  msg_t                 sel_msg;

  irqm_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .REG_AW(REG_AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .slot_msg(slot_msg), .unmask(unmask_vec)
  );

  irqm_pend #(.NUM_SLOTS(NUM_SLOTS)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt), .claim(claim_vec),
    .rise(rise_vec), .pend(pend_vec)
  );

  assign req_vec = pend_vec & unmask_vec;
  assign load    = (!msg_valid || msg_ready) && (|req_vec);

  irqm_rr_arb #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .advance(load),
    .gnt(arb_gnt), .gnt_idx(gnt_idx)
  );

  assign claim_vec = load ? arb_gnt : '0;

  always_comb begin
    sel_msg = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (arb_gnt[s]) sel_msg = slot_msg[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_addr  <= {sel_msg.addr_hi, sel_msg.addr_lo};
      msg_data  <= sel_msg.data;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irqm_chk.sv
module irqm_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [63:0]          msg_addr,
  input logic [31:0]          msg_data,
  input logic [NUM_SLOTS-1:0] gnt,
  input logic [NUM_SLOTS-1:0] pend,
  input logic [NUM_SLOTS-1:0] unmask,
  input logic [NUM_SLOTS-1:0] rise
);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_grant_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~unmask) == '0);

  assert_ready_delivers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && (|(pend & unmask))) |=> msg_valid);

  assert_pend_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~$past(rise)) == '0);
endmodule

bind irqm_array irqm_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .gnt(arb_gnt), .pend(pend_vec),
  .unmask(unmask_vec), .rise(rise_vec)
);

// File: tb/sim_irqm_array.sv
module sim_irqm_array;
  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  evt = '0;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irqm_array #(.NUM_SLOTS(N), .REG_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [31:0] lo_of(int s);   return 32'h1000_0000 + 32'(s) * 32'h100; endfunction
  function automatic logic [31:0] hi_of(int s);   return 32'h0000_0040 + 32'(s);           endfunction
  function automatic logic [31:0] dat_of(int s);  return 32'h0000_00A0 + 32'(s) * 32'h11;  endfunction
  function automatic logic [AW-1:0] off(int s, int w); return AW'(s * 16 + w * 4);         endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); evt = evt | m;
    @(negedge clk); evt = evt & ~m;
  endtask

  task automatic get_msg(output logic [63:0] a, output logic [31:0] d, output bit got);
    got = 0; a = '0; d = '0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        a = msg_addr; d = msg_data; got = 1;
        @(posedge clk);
      end
    end
  endtask

  task automatic no_msg(input int cyc, input string req);
    bit seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (msg_valid) seen = 1;
    end
    chk(!seen, req, 64'(seen), 64'd0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] ma;
    logic [31:0] md;
    bit got;
    logic [31:0] exp_seq [4];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < N; s++)
      for (int w = 0; w < 4; w++) begin
        rd(off(s, w), r);
        chk(r == 0, "R1 reset word", 64'(r), 64'd0);
      end
    chk(!msg_valid, "R1 no message after reset", 64'(msg_valid), 64'd0);

    // R2 layout sweep, R5 delivery per slot
    for (int s = 0; s < N; s++) begin
      wr(off(s, 0), lo_of(s));
      wr(off(s, 1), hi_of(s));
      wr(off(s, 2), dat_of(s));
      wr(off(s, 3), 32'h0000_0001 | (32'(s) << 8));
    end
    for (int s = 0; s < N; s++) begin
      rd(off(s, 0), r); chk(r == lo_of(s), "R2 addr low", 64'(r), 64'(lo_of(s)));
      rd(off(s, 1), r); chk(r == hi_of(s), "R2 addr high", 64'(r), 64'(hi_of(s)));
      rd(off(s, 2), r); chk(r == dat_of(s), "R2 data", 64'(r), 64'(dat_of(s)));
      rd(off(s, 3), r); chk(r == (32'h1 | (32'(s) << 8)), "R2 ctrl", 64'(r), 64'(32'h1 | (32'(s) << 8)));
    end
    for (int s = 0; s < N; s++) begin
      pulse(N'(1) << s);
      get_msg(ma, md, got);
      chk(got, "R5 message sent", 64'(got), 64'd1);
      chk(ma == {hi_of(s), lo_of(s)}, "R5 message address", ma, {hi_of(s), lo_of(s)});
      chk(md == dat_of(s), "R5 message data", 64'(md), 64'(dat_of(s)));
      no_msg(6, "R5 single message");
    end

    // R3 staged address low (slot 1)
    wr(off(1, 0), 32'hCAFE_0000);
    rd(off(1, 0), r);
    chk(r == lo_of(1), "R3 staged low not visible", 64'(r), 64'(lo_of(1)));
    pulse(4'b0010);
    get_msg(ma, md, got);
    chk(got && ma == {hi_of(1), lo_of(1)} && md == dat_of(1), "R3 old pair used",
        {ma[31:0], md}, {lo_of(1), dat_of(1)});
    wr(off(1, 2), 32'h0000_0055);
    rd(off(1, 0), r);
    chk(r == 32'hCAFE_0000, "R3 commit on data write", 64'(r), 64'h0000_0000_CAFE_0000);
    pulse(4'b0010);
    get_msg(ma, md, got);
    chk(got && ma[31:0] == 32'hCAFE_0000 && md == 32'h55, "R3 new pair used",
        {ma[31:0], md}, {32'hCAFE_0000, 32'h55});

    // R8 round robin (last granted = 1), R9 back-pressure
    @(negedge clk); msg_ready = 1'b0;
    pulse(4'b1101);
    repeat (2) @(negedge clk);
    pulse(4'b0100);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(msg_valid && msg_data == dat_of(2), "R9 held under back-pressure",
          {31'd0, msg_valid, msg_data}, {32'd1, dat_of(2)});
    end
    exp_seq[0] = dat_of(2); exp_seq[1] = dat_of(3); exp_seq[2] = dat_of(0); exp_seq[3] = dat_of(2);
    chk(msg_data == exp_seq[0], "R8 order position 0", 64'(msg_data), 64'(exp_seq[0]));
    msg_ready = 1'b1;
    @(posedge clk);
    for (int k = 1; k < 4; k++) begin
      get_msg(ma, md, got);
      chk(got && md == exp_seq[k], "R8 round-robin order", 64'(md), 64'(exp_seq[k]));
    end
    no_msg(6, "R8 queue drained");

    // R7 one-shot with level held high
    @(negedge clk); evt[0] = 1'b1;
    get_msg(ma, md, got);
    chk(got && md == dat_of(0), "R7 first message", 64'(md), 64'(dat_of(0)));
    no_msg(12, "R7 no repeat while held");
    @(negedge clk); evt[0] = 1'b0;
    no_msg(4, "R7 no message on fall");

    // R4 upper ctrl bits inert, R6 pending across mask
    wr(off(3, 3), 32'hABCD_0300);
    rd(off(3, 3), r);
    chk(r == 32'hABCD_0300, "R4 ctrl readback", 64'(r), 64'h0000_0000_ABCD_0300);
    pulse(4'b1000);
    no_msg(8, "R6 masked slot silent");
    wr(off(3, 3), 32'hABCD_0301);
    get_msg(ma, md, got);
    chk(got && md == dat_of(3), "R6 pending sent on unmask", 64'(md), 64'(dat_of(3)));
    wr(off(3, 3), 32'hABCD_0300);
    wr(off(3, 3), 32'hABCD_0301);
    no_msg(8, "R6 pending cleared");

    // R4 release: all four words zero
    for (int w = 0; w < 4; w++) wr(off(2, w), 32'h0);
    for (int w = 0; w < 4; w++) begin
      rd(off(2, w), r);
      chk(r == 0, "R4 released slot zero", 64'(r), 64'd0);
    end
    pulse(4'b0100);
    no_msg(8, "R4 released slot masked");

    // R10 out-of-range slot
    for (int w = 0; w < 4; w++) wr(off(N, w), 32'hFFFF_FFFF);
    rd(off(N, 2), r);
    chk(r == 0, "R10 out-of-range read", 64'(r), 64'd0);
    rd(off(15, 3), r);
    chk(r == 0, "R10 top index read", 64'(r), 64'd0);
    rd(off(0, 2), r);
    chk(r == dat_of(0), "R10 slot 0 untouched", 64'(r), 64'(dat_of(0)));
    rd(off(0, 3), r);
    chk(r == 32'h1, "R10 slot 0 ctrl untouched", 64'(r), 64'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule